// File: doc/BRIEF.md
# I2C Target with Bus Status Monitor

This block is a 7-bit-address I2C target. It runs from a peripheral clock that must be at least eight times the bus bit rate. SCL and SDA come in raw and pass through a two-flop synchronizer. START and STOP are recognised as SDA edges while SCL is high. A decoded address byte that matches `own_addr` selects the block. The R/W bit of that byte then picks whether the host receives bytes on `rx_byte` or supplies them on `tx_byte`. The block never holds SCL low.

Alongside the transfer engine sits a contention and acknowledge monitor. On every SCL rising edge of a bit the block is responsible for, it compares the sampled SDA level with the level it meant to produce. A bit it left released but found low sets a sticky mismatch flag. After each byte it sends, it latches a master NAK into a sticky flag. Both flags clear only through a write-1 mask. Together they raise one interrupt, gated by a shared enable. The `sel` output tells software whether the current transfer addresses this block. A mismatch raised during an address the block did not own, where another target answered ACK, can then be discarded.

The state machine has eight states. IDLE waits for a START. ADDR shifts in the address byte. ADDR_ACK drives ACK or leaves NAK. RX shifts in a data byte. RX_ACK drives ACK. TX shifts out a data byte. TX_ACK samples the master's acknowledge. SKIP waits for the next START or STOP. START moves any state to ADDR and STOP moves any state to IDLE. On an SCL falling edge these moves apply:
- ADDR→ADDR_ACK after eight bits.
- ADDR_ACK→SKIP on a miss, →TX on a read, →RX on a write.
- RX→RX_ACK after eight bits, and RX_ACK→RX.
- TX→TX_ACK after eight bits.
- TX_ACK→TX after an ACK, or →SKIP after a NAK.

Top module: `i2c_target_mon`

## Requirements
- R1: The address byte is taken MSB first: seven address bits, then R/W in the last bit (1 = the master reads). A match with `own_addr` is answered with ACK, which means `sda_pull_low` is high during the ninth clock. A miss leaves SDA released (NAK). After a miss the block ignores the bus until the next START or STOP.
- R2: `sel` goes to 1 when an address byte matches and to 0 when an address byte misses, including one after a repeated START. It also goes to 0 on STOP.
- R3: In a write transfer, each received byte appears on `rx_byte` with a one-cycle `rx_strobe` after its eighth bit. The block answers it with ACK.
- R4: In a read transfer, `tx_byte` is captured with a one-cycle `tx_take` and sent MSB first. `sda_pull_low` changes only after an SCL falling edge, a START or a STOP.
- R5: On the SCL rising edge of a bit the block answers for (ACK/NAK bit of the address, transmitted data bit, ACK of received data), a released bit sampled low sets `flags[0]` (mismatch). A bit the block drives low never sets it.
- R6: After each transmitted byte, SDA high on the ninth clock (NAK) sets `flags[1]` and the block releases SDA until the next START or STOP. SDA low (ACK) leaves `flags[1]` unchanged and loads the next byte.
- R7: A flag, once set, holds until a cycle with `clr_wr` high and a 1 in its bit of `clr_mask`. A 0 in the mask leaves it set.
- R8: `irq` is 1 exactly when `irq_en` is 1 and at least one flag is set.
- R9: After reset, `sda_pull_low`, `sel`, `flags`, `irq`, `rx_strobe` and `tx_take` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level |
| own_addr | input | 7 | Address this target answers to |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| tx_byte | input | 8 | Byte to send in a read transfer |
| tx_take | output | 1 | Pulse: `tx_byte` captured |
| rx_byte | output | 8 | Last byte received |
| rx_strobe | output | 1 | Pulse: `rx_byte` updated |
| sel | output | 1 | Current transfer addresses this block |
| flags | output | 2 | Sticky status: bit0 mismatch, bit1 NAK received |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 2 | Write-1-to-clear mask, same bit order as `flags` |
| irq_en | input | 1 | Shared enable for the status interrupt |
| irq | output | 1 | Status interrupt |

## Verification
The address decoder is swept over all 128 addresses. This separates a correct match from any off-by-one or bit-order fault in the comparison, and shows that a miss neither selects nor raises a false mismatch. Write transfers use sixteen arithmetic byte patterns. They tell a correct shift order and strobe count apart from a dropped or doubled bit, and show that a driven ACK never counts as contention. Read transfers mix all-ones, all-zeros and alternating bytes with ACK then NAK. A second target's ACK and a forced low on a released data bit prove the mismatch path, and a repeated START to a foreign address proves that `sel` is dropped.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_e;

    localparam int FLAG_MISMATCH = 0;
    localparam int FLAG_NAK      = 1;
    localparam int N_FLAGS       = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
            sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
            scl_q     <= scl_s;
            sda_q     <= sda_s;
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_bus_flags.sv
module i2c_bus_flags import i2c_tgt_pkg::*; #(
    parameter int NF = N_FLAGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_req,
    input  logic          clr_wr,
    input  logic [NF-1:0] clr_mask,
    input  logic          irq_en,
    output logic [NF-1:0] flags,
    output logic          irq
);
    logic [NF-1:0] clr_vec;

    assign clr_vec = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_req;
    end

    assign irq = irq_en & (|flags);

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flags & $past(flags)) == $past(flags))); // R7

    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & ~$past(set_req)) == '0)); // R5
endmodule

// File: rtl/i2c_target_mon.sv
module i2c_target_mon import i2c_tgt_pkg::*; #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [ADDR_W-1:0]   own_addr,
    output logic                sda_pull_low,
    input  logic [DATA_W-1:0]   tx_byte,
    output logic                tx_take,
    output logic [DATA_W-1:0]   rx_byte,
    output logic                rx_strobe,
    output logic                sel,
    output logic [N_FLAGS-1:0]  flags,
    input  logic                clr_wr,
    input  logic [N_FLAGS-1:0]  clr_mask,
    input  logic                irq_en,
    output logic                irq
);
    localparam int               CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    tgt_state_e         state, nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [DATA_W-1:0]  shreg;
    logic               drv_low;
    logic               rd_dir;
    logic               nak_seen;
    logic               sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic               addr_hit, byte_done, answering;
    logic [N_FLAGS-1:0] set_req;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    assign addr_hit  = (shreg[DATA_W-1 -: ADDR_W] == own_addr);
    assign byte_done = (bit_cnt == LAST_BIT);
    assign answering = (state == ST_ADDR_ACK) || (state == ST_TX) || (state == ST_RX_ACK);

    always_comb begin
        set_req                = '0;
        set_req[FLAG_MISMATCH] = scl_rise && !start_evt && !stop_evt && answering
                                 && !drv_low && !sda_lvl;
        set_req[FLAG_NAK]      = scl_rise && (state == ST_TX_ACK) && sda_lvl;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (start_evt)      nxt = ST_ADDR;
        else if (stop_evt)  nxt = ST_IDLE;
        else if (scl_fall) begin
            unique case (state)
                ST_ADDR:     if (byte_done) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK: nxt = !sel ? ST_SKIP : (rd_dir ? ST_TX : ST_RX);
                ST_RX:       if (byte_done) nxt = ST_RX_ACK;
                ST_RX_ACK:   nxt = ST_RX;
                ST_TX:       if (byte_done) nxt = ST_TX_ACK;
                ST_TX_ACK:   nxt = nak_seen ? ST_SKIP : ST_TX;
                default:     nxt = state;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            drv_low   <= 1'b0;
            rd_dir    <= 1'b0;
            nak_seen  <= 1'b0;
            sel       <= 1'b0;
            rx_byte   <= '0;
            rx_strobe <= 1'b0;
            tx_take   <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            tx_take   <= 1'b0;
            if (start_evt) begin
                bit_cnt <= '0;
                drv_low <= 1'b0;
            end else if (stop_evt) begin
                drv_low <= 1'b0;
                sel     <= 1'b0;
            end else if (scl_rise) begin
                unique case (state)
                    ST_ADDR, ST_RX: begin
                        shreg   <= {shreg[DATA_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_TX:     bit_cnt  <= bit_cnt + 1'b1;
                    ST_TX_ACK: nak_seen <= sda_lvl;
                    default:   ;
                endcase
            end else if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (byte_done) begin
                        sel     <= addr_hit;
                        rd_dir  <= shreg[0];
                        drv_low <= addr_hit;
                    end
                    ST_ADDR_ACK: begin
                        bit_cnt <= '0;
                        if (sel && rd_dir) begin
                            shreg   <= tx_byte;
                            tx_take <= 1'b1;
                            drv_low <= ~tx_byte[DATA_W-1];
                        end else begin
                            drv_low <= 1'b0;
                        end
                    end
                    ST_RX: if (byte_done) begin
                        rx_byte   <= shreg;
                        rx_strobe <= 1'b1;
                        drv_low   <= 1'b1;
                    end
                    ST_RX_ACK: begin
                        bit_cnt <= '0;
                        drv_low <= 1'b0;
                    end
                    ST_TX: begin
                        if (byte_done) begin
                            drv_low <= 1'b0;
                        end else begin
                            shreg   <= shreg << 1;
                            drv_low <= ~shreg[DATA_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        bit_cnt <= '0;
                        if (!nak_seen) begin
                            shreg   <= tx_byte;
                            tx_take <= 1'b1;
                            drv_low <= ~tx_byte[DATA_W-1];
                        end else begin
                            drv_low <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_low = drv_low;

    i2c_bus_flags #(.NF(N_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> $past(scl_fall || start_evt || stop_evt)); // R4

    AST_SEL_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sel); // R2

    AST_QUIET_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP) |-> !sda_pull_low); // R1
endmodule

// File: tb/i2c_target_mon_bench.sv
module i2c_target_mon_bench;
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, m_sda = 1'b1, other_low = 1'b0;
    logic       pull;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_take, rx_strobe, sel, irq;
    logic [7:0] rx_byte;
    logic [1:0] flags;
    logic       clr_wr = 1'b0;
    logic [1:0] clr_mask = 2'b00;
    logic       irq_en = 1'b0;
    wire        sda_bus = m_sda & ~pull & ~other_low;

    int n_chk = 0, n_fail = 0, rx_cnt = 0, tx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_target_mon u_i2c_target_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .own_addr(OWN), .sda_pull_low(pull), .tx_byte(tx_byte),
        .tx_take(tx_take), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
        .sel(sel), .flags(flags), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .irq_en(irq_en), .irq(irq)
    );

    always @(posedge clk) begin
        if (rx_strobe) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_byte; end
        if (tx_take) tx_cnt <= tx_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

    task automatic bit_out(input logic b);
        cyc(4); m_sda = b; cyc(4); scl = 1'b1; cyc(8); scl = 1'b0;
    endtask

    task automatic bit_in(output logic b, input logic jam);
        cyc(4); m_sda = 1'b1; other_low = jam; cyc(4); scl = 1'b1;
        cyc(5); b = sda_bus; cyc(3); scl = 1'b0; other_low = 1'b0;
    endtask

    task automatic do_start;
        if (!scl) begin cyc(4); m_sda = 1'b1; cyc(4); scl = 1'b1; cyc(8); end
        m_sda = 1'b0; cyc(8); scl = 1'b0;
    endtask

    task automatic do_stop;
        cyc(4); m_sda = 1'b0; cyc(4); scl = 1'b1; cyc(8); m_sda = 1'b1; cyc(8);
    endtask

    task automatic byte_out(input logic [7:0] v, output logic ack, input logic jam_ack);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(ack, jam_ack);
    endtask

    task automatic byte_in(output logic [7:0] v, input int jam_bit);
        logic b;
        for (int i = 7; i >= 0; i--) begin bit_in(b, jam_bit == i); v[i] = b; end
    endtask

    task automatic clear(input logic [1:0] m);
        @(negedge clk); clr_wr = 1'b1; clr_mask = m;
        @(negedge clk); clr_wr = 1'b0; clr_mask = 2'b00; cyc(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v, b;
        logic [7:0] pat [4];
        pat[0] = 8'hC3; pat[1] = 8'h5A; pat[2] = 8'hFF; pat[3] = 8'h00;

        cyc(5); rst_n = 1'b1; cyc(4);
        // R9 reset state
        chk("R9 pull", pull, 0); chk("R9 sel", sel, 0);
        chk("R9 flags", flags, 0); chk("R9 irq", irq, 0);

        // R1/R2 address sweep
        for (int a = 0; a < 128; a++) begin
            do_start;
            byte_out({7'(a), 1'b0}, ack, 1'b0);
            chk($sformatf("R1 ack addr %0d", a), ack, (a == OWN) ? 0 : 1);
            chk($sformatf("R2 sel addr %0d", a), sel, (a == OWN) ? 1 : 0);
            do_stop;
            chk("R2 sel after stop", sel, 0);
        end
        chk("R5 no mismatch during sweep", flags, 0);

        // R5 foreign ACK on a missed address, R2 sel low, R8 irq gating
        do_start;
        byte_out({OWN ^ 7'h01, 1'b0}, ack, 1'b1);
        chk("R5 foreign ack flags mismatch", flags, 1);
        chk("R2 sel on foreign address", sel, 0);
        do_stop;
        chk("R8 irq disabled", irq, 0);
        irq_en = 1'b1; cyc(1);
        chk("R8 irq enabled", irq, 1);
        clear(2'b10);
        chk("R7 mask 0 keeps mismatch", flags, 1);
        clr_wr = 1'b1; cyc(1); clr_wr = 1'b0; cyc(1);
        chk("R7 all-zero mask keeps mismatch", flags, 1);
        clear(2'b01);
        chk("R7 write 1 clears mismatch", flags, 0);
        chk("R8 irq drops", irq, 0);

        // R3 write sweep
        do_start;
        byte_out({OWN, 1'b0}, ack, 1'b0);
        chk("R1 write address ack", ack, 0);
        for (int k = 0; k < 16; k++) begin
            b = 8'(k * 37 + 11);
            byte_out(b, ack, 1'b0);
            chk("R3 data ack", ack, 0);
            chk("R3 rx byte", rx_last, b);
            chk("R3 rx count", rx_cnt, k + 1);
        end
        do_stop;
        chk("R5 driven ACKs leave mismatch clear", flags, 0);

        // R4/R6 read transfer
        tx_byte = pat[0];
        do_start;
        byte_out({OWN, 1'b1}, ack, 1'b0);
        chk("R1 read address ack", ack, 0);
        for (int k = 0; k < 4; k++) begin
            byte_in(v, -1);
            tx_byte = pat[(k + 1) % 4];
            chk("R4 tx byte", v, pat[k]);
            bit_out(k == 3);
            chk("R6 nak flag", flags[1], (k == 3) ? 1 : 0);
        end
        cyc(6);
        chk("R6 released after nak", pull, 0);
        chk("R4 tx take count", tx_cnt, 4);
        chk("R5 clean read no mismatch", flags[0], 0);
        chk("R8 irq on nak", irq, 1);
        do_stop;
        clear(2'b10);
        chk("R7 nak cleared", flags, 0);

        // R5 contention on a released data bit
        tx_byte = 8'hFF;
        do_start;
        byte_out({OWN, 1'b1}, ack, 1'b0);
        byte_in(v, 3);
        chk("R5 jammed bit seen", v, 8'hF7);
        chk("R5 mismatch on tx", flags[0], 1);
        bit_out(1'b1);
        do_stop;
        clear(2'b11);
        chk("R7 both cleared", flags, 0);

        // R2 repeated START with a foreign address
        do_start;
        byte_out({OWN, 1'b0}, ack, 1'b0);
        chk("R2 selected before restart", sel, 1);
        do_start;
        byte_out({OWN ^ 7'h40, 1'b0}, ack, 1'b0);
        chk("R1 restart foreign nak", ack, 1);
        chk("R2 sel cleared by foreign restart", sel, 0);
        do_stop;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule